// File: doc/BRIEF.md
# Multi-Rate Half-Band Interpolator

This block raises the sample rate of a 24-bit stereo PCM stream. Its output always runs at eight times the normal-mode base rate. A two-bit speed code tells it the input rate. At normal speed the input passes through three cascaded x2 half-band stages. At double speed the first stage is skipped. At quad speed only the last stage runs. Every stage is linear phase and uses the symmetric kernel (-1, 0, 9, 16, 9, 0, -1)/16.

Samples enter through a valid/ready handshake and wait in a one-deep holding register. Results leave on a one-cycle strobe, once every `SLOT_CLKS` clock cycles. Inside each output slot, a single arithmetic unit is shared in turn by every active stage and both channels. Changing the speed code clears all filter history. The block then waits for the next input sample before it starts again.

Top module: `ipf_interp`

## Requirements
- R1: After reset `out_valid` is low and `in_ready` is high.
- R2: Every stage keeps a four-word history n0 (newest) to n3 per channel. An even step shifts one new word into the history and outputs n2. The odd step that follows outputs floor((9*(n1+n2) - n0 - n3 + 8) / 16). Both are computed on the history after that push. Every history word starts at zero.
- R3: Speed code 0 runs all three stages, giving 8 output samples per input sample.
- R4: Speed code 1 bypasses the first stage, giving 4 outputs per input. The bypassed stage's history stays zero.
- R5: Speed code 2 or 3 bypasses the first two stages, giving 2 outputs per input.
- R6: Once running, `out_valid` is a one-cycle pulse repeated every `SLOT_CLKS` clock cycles.
- R7: The input holds one sample. `in_ready` is low from the cycle after an accepted sample until the filter takes that sample.
- R8: The odd-step result saturates to the range -8388608 to 8388607.
- R9: A change of `spd_mode` clears every history word, drops any held sample and stops the output strobe. The next stream then matches a stream that starts from reset.
- R10: Left and right run the same arithmetic on separate histories, so neither channel affects the other.
- R11: No output strobe appears until the first sample is accepted after reset or after a mode change. That sample is taken in the first output slot.
- R12: If no sample is held when the first active stage needs one, that stage takes zero instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-frequency clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spd_mode | input | 2 | Speed code: 0 normal, 1 double, 2 or 3 quad |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Holding register can take a sample |
| in_l | input | DW | Left input word, two's complement |
| in_r | input | DW | Right input word, two's complement |
| out_valid | output | 1 | Output strobe, one cycle per slot |
| out_l | output | DW | Left interpolated word |
| out_r | output | DW | Right interpolated word |

## Verification
Stale history shows up at the output ports within the next few output slots. A wrong history word in a stage changes that stage's next odd result. A wrong stage order or phase decode corrupts the output sequence from its first sample. Filter history that survives a mode change shows up in the first few outputs after the restart. A slip in the slot sequencer shifts the output strobe spacing or the input acceptance rate right away. The bench sends impulses, ramps, pseudo-random words and full-scale patterns through each speed code. It compares every output word, including the zero-filled tail, against an arithmetic cascade computed independently.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  localparam int NUM_STAGES = 3;

  // index of the first half-band stage that runs for a speed code
  function automatic logic [1:0] first_stage(input logic [1:0] code);
    case (code)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  // a stage steps in a slot when the slot-phase bits below its own are zero
  function automatic logic stage_fires(input logic [NUM_STAGES-1:0] ph, input logic [1:0] stg);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NUM_STAGES; i++)
      if (i < (NUM_STAGES - 1 - int'(stg)) && ph[i]) ok = 1'b0;
    return ok;
  endfunction

  // its own phase bit picks the even (push) or odd (midpoint) step
  function automatic logic stage_even(input logic [NUM_STAGES-1:0] ph, input logic [1:0] stg);
    logic ev;
    ev = 1'b0;
    for (int i = 0; i < NUM_STAGES; i++)
      if (i == (NUM_STAGES - 1 - int'(stg))) ev = !ph[i];
    return ev;
  endfunction
endpackage

// File: rtl/ipf_seq.sv
module ipf_seq #(
  parameter int SLOT_CLKS = 8,
  parameter int NSTG      = 3,
  parameter int CW        = $clog2(SLOT_CLKS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            start,
  output logic            run,
  output logic [CW-1:0]   cyc,
  output logic [NSTG-1:0] ph,
  output logic            slot_end
);
  assign slot_end = run && (cyc == CW'(SLOT_CLKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      run <= 1'b0;
      cyc <= '0;
      ph  <= '0;
    end else if (!run) begin
      if (start) run <= 1'b1;
    end else begin
      cyc <= slot_end ? '0 : cyc + 1'b1;
      if (slot_end) ph <= ph + 1'b1;
    end
  end
endmodule

// File: rtl/ipf_taps.sv
module ipf_taps #(
  parameter int DW   = 24,
  parameter int NSTG = 3,
  parameter int NCH  = 2,
  parameter int NTAP = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 push,
  input  logic [1:0]           sel_stg,
  input  logic                 sel_ch,
  input  logic signed [DW-1:0] x,
  input  logic [1:0]           min_stg,
  output logic signed [DW-1:0] tap_o [NTAP]
);
  localparam int NLINE = NSTG * NCH;
  logic signed [DW-1:0] flat [NLINE][NTAP];

  for (genvar s = 0; s < NSTG; s++) begin : g_stg
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic signed [DW-1:0] q [NTAP];
      logic hit, all_zero;
      assign hit = push && (sel_stg == 2'(s)) && (sel_ch == 1'(c));

      always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
          for (int k = 0; k < NTAP; k++) q[k] <= '0;
        end else if (hit) begin
          q[0] <= x;
          for (int k = 1; k < NTAP; k++) q[k] <= q[k-1];
        end
      end

      always_comb begin
        all_zero = 1'b1;
        for (int k = 0; k < NTAP; k++) if (q[k] != '0) all_zero = 1'b0;
      end
      assign flat[s*NCH+c] = q;

      AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) clear |=> all_zero); // R9
      AST_BYPASS_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (2'(s) < min_stg) |-> all_zero); // R4
    end
  end

  always_comb begin
    int idx;
    idx = (int'(sel_stg) < NSTG) ? int'(sel_stg) * NCH + int'(sel_ch) : 0;
    tap_o = flat[idx];
  end
endmodule

// File: rtl/ipf_mac.sv
module ipf_mac #(
  parameter int DW    = 24,
  parameter int GUARD = 5
) (
  input  logic                 odd,
  input  logic signed [DW-1:0] t0,
  input  logic signed [DW-1:0] t1,
  input  logic signed [DW-1:0] t2,
  input  logic signed [DW-1:0] t3,
  output logic signed [DW-1:0] y
);
  localparam int AW = DW + GUARD;
  localparam logic signed [AW-1:0] POS_LIM = AW'((64'sd1 <<< (DW-1)) - 64'sd1);
  localparam logic signed [AW-1:0] NEG_LIM = -POS_LIM - AW'(1);

  // midpoint of the symmetric half-band kernel, rounded then clipped
  function automatic logic signed [DW-1:0] hb_mid(
      input logic signed [DW-1:0] a, input logic signed [DW-1:0] b,
      input logic signed [DW-1:0] c, input logic signed [DW-1:0] d);
    logic signed [AW-1:0] inner, outer, acc, q;
    inner = AW'(b) + AW'(c);
    outer = AW'(a) + AW'(d);
    acc   = (inner <<< 3) + inner - outer + AW'(8);
    q     = acc >>> 4;
    if (q > POS_LIM)      return POS_LIM[DW-1:0];
    else if (q < NEG_LIM) return NEG_LIM[DW-1:0];
    else                  return q[DW-1:0];
  endfunction

  assign y = odd ? hb_mid(t0, t1, t2, t3) : t1;
endmodule

// File: rtl/ipf_interp.sv
module ipf_interp #(
  parameter int DW        = 24,
  parameter int SLOT_CLKS = 8,
  parameter int GUARD     = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           spd_mode,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_l,
  input  logic signed [DW-1:0] in_r,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_l,
  output logic signed [DW-1:0] out_r
);
  import hbi_pkg::*;
  localparam int NSTG      = NUM_STAGES;
  localparam int NCH       = 2;
  localparam int NTAP      = 4;
  localparam int CW        = $clog2(SLOT_CLKS);
  localparam int LAST_CALC = 2 * NSTG;

  logic [1:0]           mode_q, first_stg, sel_stg, prev_stg;
  logic                 flush, run, slot_end, accept, start, sel_ch;
  logic                 active, fires, even_step, do_step, push, from_input, consume;
  logic [CW-1:0]        cyc;
  logic [NSTG-1:0]      ph;
  logic                 buf_full;
  logic signed [DW-1:0] buf_l, buf_r, x_new, y;
  logic signed [DW-1:0] taps [NTAP];
  logic signed [DW-1:0] res [NSTG][NCH];

  // mode tracking and restart
  assign flush     = (spd_mode != mode_q);
  assign first_stg = first_stage(mode_q);

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= 2'd0;
    else        mode_q <= spd_mode;
  end

  // one-deep input holding register
  assign in_ready = !buf_full && !flush;
  assign accept   = in_valid && in_ready;
  assign start    = accept && !run;

  ipf_seq #(.SLOT_CLKS(SLOT_CLKS), .NSTG(NSTG), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .flush(flush), .start(start),
    .run(run), .cyc(cyc), .ph(ph), .slot_end(slot_end)
  );

  // slot schedule: cycle 2*stage+channel uses the shared arithmetic
  assign active     = run && (cyc < CW'(LAST_CALC));
  assign sel_stg    = 2'(cyc >> 1);
  assign sel_ch     = cyc[0];
  assign prev_stg   = (sel_stg == 2'd0) ? 2'd0 : sel_stg - 2'd1;
  assign fires      = stage_fires(ph, sel_stg);
  assign even_step  = stage_even(ph, sel_stg);
  assign do_step    = active && (sel_stg >= first_stg) && fires;
  assign push       = do_step && even_step;
  assign from_input = (sel_stg == first_stg);
  assign consume    = push && from_input && sel_ch;
  assign x_new      = from_input ? (buf_full ? (sel_ch ? buf_r : buf_l) : '0)
                                 : res[prev_stg][sel_ch];

  ipf_taps #(.DW(DW), .NSTG(NSTG), .NCH(NCH), .NTAP(NTAP)) u_taps (
    .clk(clk), .rst_n(rst_n), .clear(flush), .push(push),
    .sel_stg(sel_stg), .sel_ch(sel_ch), .x(x_new), .min_stg(first_stg), .tap_o(taps)
  );

  ipf_mac #(.DW(DW), .GUARD(GUARD)) u_mac (
    .odd(!even_step), .t0(taps[0]), .t1(taps[1]), .t2(taps[2]), .t3(taps[3]), .y(y)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      buf_full <= 1'b0;
      buf_l    <= '0;
      buf_r    <= '0;
    end else if (accept) begin
      buf_full <= 1'b1;
      buf_l    <= in_l;
      buf_r    <= in_r;
    end else if (consume) begin
      buf_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      for (int s = 0; s < NSTG; s++)
        for (int c = 0; c < NCH; c++) res[s][c] <= '0;
    end else if (do_step) begin
      res[sel_stg][sel_ch] <= y;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      out_valid <= 1'b0;
      out_l     <= '0;
      out_r     <= '0;
    end else begin
      out_valid <= run && (cyc == CW'(LAST_CALC));
      if (run && (cyc == CW'(LAST_CALC))) begin
        out_l <= res[NSTG-1][0];
        out_r <= res[NSTG-1][1];
      end
    end
  end

  // strobe spacing monitor
  int  gap_cnt;
  logic had_out;
  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      gap_cnt <= 0;
      had_out <= 1'b0;
    end else if (out_valid) begin
      gap_cnt <= 0;
      had_out <= 1'b1;
    end else if (gap_cnt < SLOT_CLKS) begin
      gap_cnt <= gap_cnt + 1;
    end
  end

  AST_STROBE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && had_out) |-> (gap_cnt == SLOT_CLKS - 1)); // R6
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n) flush |=> (!out_valid && !run)); // R9
  AST_HOLD_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) $rose(buf_full) |-> $past(in_valid && in_ready)); // R7
endmodule

// File: tb/sim_ipf_interp.sv
module sim_ipf_interp;
  localparam int PERIOD = 10;
  localparam int DW     = 24;
  localparam int SLOT   = 8;
  localparam int MAXV   = 8388607;
  localparam int MINV   = -8388608;

  typedef int iq_t[$];

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_r = 2'd0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [DW-1:0] in_l = '0, in_r = '0;
  logic out_valid;
  logic signed [DW-1:0] out_l, out_r;

  int vectors = 0;
  int fails = 0;
  int ncyc = 0;
  iq_t got_l, got_r, got_t;

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) ncyc <= ncyc + 1;

  ipf_interp #(.DW(DW), .SLOT_CLKS(SLOT)) u0 (
    .clk(clk), .rst_n(rst_n), .spd_mode(mode_r), .in_valid(in_valid), .in_ready(in_ready),
    .in_l(in_l), .in_r(in_r), .out_valid(out_valid), .out_l(out_l), .out_r(out_r)
  );

  always @(negedge clk) begin
    if (out_valid) begin
      got_l.push_back(int'(out_l));
      got_r.push_back(int'(out_r));
      got_t.push_back(ncyc);
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // one x2 half-band stage from zero history
  function automatic iq_t hb_up(input iq_t xi);
    iq_t yo;
    int h0 = 0, h1 = 0, h2 = 0, h3 = 0;
    foreach (xi[i]) begin
      int s, r;
      h3 = h2; h2 = h1; h1 = h0; h0 = xi[i];
      yo.push_back(h2);
      s = 9 * (h1 + h2) - h0 - h3;
      r = (s + 8) >>> 4;
      if (r > MAXV) r = MAXV;
      if (r < MINV) r = MINV;
      yo.push_back(r);
    end
    return yo;
  endfunction

  function automatic int n_stages(input int mode);
    return (mode == 0) ? 3 : (mode == 1) ? 2 : 1;
  endfunction

  function automatic iq_t cascade(input iq_t xi, input int mode);
    iq_t v = xi;
    for (int k = 0; k < n_stages(mode); k++) v = hb_up(v);
    return v;
  endfunction

  function automatic int pv(input int pat, input int i, input int ch);
    int h;
    case (pat)
      0: return (i == 2) ? (ch ? -3000000 : 4000000) : 0;
      1: return ch ? -(i * 37111 - 300000) : (i * 37111 - 300000);
      2: begin
        h = i * 1103515245 + ch * 12345 + 7;
        h = h ^ (h >>> 13);
        h = h * 69069 + 1;
        return (h <<< 8) >>> 8;
      end
      default: return ((i % 4) < 2) ^ (ch == 1) ? MAXV : MINV;
    endcase
  endfunction

  task automatic send(input int l, input int r);
    @(negedge clk);
    in_valid = 1'b1;
    in_l = DW'(l);
    in_r = DW'(r);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 ready low while held", int'(in_ready), 0);
  endtask

  task automatic run_case(input int mode, input int pat, input int n, input string mtag, input string ptag);
    iq_t xl, xr, el, er;
    int w, need, fanout, bad_gap;
    @(negedge clk);
    mode_r = 2'(mode);
    repeat (3) @(negedge clk);
    got_l.delete(); got_r.delete(); got_t.delete();
    repeat (40) @(negedge clk);
    check("R11 no strobe before first sample", got_l.size(), 0);
    for (int i = 0; i < n; i++) begin
      xl.push_back(pv(pat, i, 0));
      xr.push_back(pv(pat, i, 1));
    end
    for (int i = 0; i < n; i++) send(xl[i], xr[i]);
    for (int i = 0; i < 4; i++) begin
      xl.push_back(0);
      xr.push_back(0);
    end
    el = cascade(xl, mode);
    er = cascade(xr, mode);
    fanout = 1 << n_stages(mode);
    need = el.size();
    w = 0;
    while (got_l.size() < need && w < 6000) begin
      @(negedge clk);
      w++;
    end
    if (got_l.size() < need) begin
      vectors++;
      fails++;
      $display("FAIL %s timeout: got %0d outputs expected %0d", mtag, got_l.size(), need);
    end else begin
      for (int i = 0; i < need; i++) begin
        if (i >= n * fanout) begin
          check($sformatf("R12 %s tail[%0d] L", mtag, i), got_l[i], el[i]);
          check($sformatf("R12 %s tail[%0d] R", mtag, i), got_r[i], er[i]);
        end else begin
          check($sformatf("%s %s out[%0d] L", mtag, ptag, i), got_l[i], el[i]);
          check($sformatf("R10 %s out[%0d] R", mtag, i), got_r[i], er[i]);
        end
      end
      bad_gap = SLOT;
      for (int i = 1; i < need; i++)
        if (got_t[i] - got_t[i-1] != SLOT) bad_gap = got_t[i] - got_t[i-1];
      check("R6 strobe spacing", bad_gap, SLOT);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, got %0d expected %0d cycles", ncyc, 190000);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after reset", int'(out_valid), 0);
    check("R1 in_ready after reset", int'(in_ready), 1);

    for (int p = 0; p < 4; p++) begin
      string ptag;
      ptag = (p == 3) ? "R8" : "R2";
      run_case(0, p, 16, "R3", ptag);
      run_case(1, p, 16, "R4", ptag);
      run_case(2, p, 16, "R5", ptag);
      run_case(3, p, 16, "R5", ptag);
    end

    // leave live history and a held sample, then change mode mid-stream
    @(negedge clk);
    mode_r = 2'd1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 6; i++) send(MAXV, MINV);
    @(negedge clk);
    in_valid = 1'b1;
    in_l = DW'(MAXV);
    in_r = DW'(MAXV);
    @(negedge clk);
    in_valid = 1'b0;
    run_case(2, 2, 12, "R9", "R2");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule